// File: doc/BRIEF.md
# Multichannel Interrupt Bid Arbiter

This block chooses which interrupt source a processor should service next in a four-channel serial controller with one shared counter/timer. Each channel has four possible requesters: received data waiting, transmit space free, a change in the break condition, and a change of state on an input. Every enabled source that has something to report forms a 6-bit bid at the same moment. The bid's upper three bits are an urgency count and its lower three bits are a fixed type code. For receive and transmit sources the count is the number of bytes in the FIFO or the number of free FIFO places. For event sources it is fixed at seven. The largest bid wins, but only if it is strictly above a programmable threshold. Among channels with equal bids the lowest channel number wins.

A registered active-low interrupt request follows the presence of a qualifying bid. The winner's channel number, type and count are captured in a current-interrupt register. The capture happens on the rising edge of a hardware acknowledge level, or on a one-cycle update command when no acknowledge is wired. The register holds while the acknowledge stays high. An 8-bit vector is formed from the current-interrupt register and a base byte. Its three top bits always come from the base byte, and a control field selects whether the channel, the type, or both replace lower bits.

Top module: `intbid_arb`

## Requirements
- R1: A bid is {count[2:0], type[2:0]}. The type codes are: 011 for receive without error, 111 for receive with the error flag set, 010 for transmit, 100 for break change, 001 for change of state and 101 for the counter/timer. Receive and transmit sources bid only when their count is nonzero. Event sources and the counter/timer bid with count 7.
- R2: A source whose enable bit is low never bids.
- R3: A bid qualifies only when it is strictly greater than the 6-bit threshold.
- R4: The winner is the qualifying bid of greatest value. Between channels with equal bids, the lowest channel number wins.
- R5: The counter/timer bids as channel 0. It wins only when its bid is strictly greater than every channel's bid.
- R6: `irq_n_o` is a register. One cycle after the inputs present a qualifying bid it is 0, and one cycle after they present none it is 1.
- R7: The current-interrupt register is {channel[1:0], type[2:0], count[2:0]}. It loads at a clock edge where `ack_i` is high and was low at the previous edge. A load with no qualifying bid gives 0.
- R8: While `ack_i` stays high and `upd_i` is low, the current-interrupt register does not change.
- R9: `upd_i` high at a clock edge loads the current winner into the current-interrupt register, whatever the state of `ack_i`.
- R10: `vec_o` is registered from the current-interrupt register one cycle later. The modes of `vctl_i` are: 00 gives the base byte, 01 gives {base[7:2], channel}, 10 gives {base[7:3], type}, and 11 gives {base[7:5], type, channel}.
- R11: Synchronous reset sets `irq_n_o` to 1 and sets the current-interrupt register and the vector to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_fill_i | input | 12 | Receive FIFO byte count, 3 bits per channel |
| rx_err_i | input | 4 | Receive error flag per channel |
| tx_free_i | input | 12 | Transmit FIFO free places, 3 bits per channel |
| brk_i | input | 4 | Break-change event per channel |
| cos_i | input | 4 | Change-of-state event per channel |
| ct_i | input | 1 | Counter/timer event |
| en_rx_i | input | 4 | Receive source enables |
| en_tx_i | input | 4 | Transmit source enables |
| en_brk_i | input | 4 | Break source enables |
| en_cos_i | input | 4 | Change-of-state source enables |
| en_ct_i | input | 1 | Counter/timer enable |
| thresh_i | input | 6 | Bid threshold |
| base_i | input | 8 | Vector base byte |
| vctl_i | input | 2 | Vector substitution mode |
| ack_i | input | 1 | Interrupt acknowledge level |
| upd_i | input | 1 | Update command for the current-interrupt register |
| irq_n_o | output | 1 | Active-low interrupt request |
| cir_o | output | 8 | Current-interrupt register |
| vec_o | output | 8 | Acknowledge vector |

## Verification
The bench targets the cross-channel tie: a design that kept the last equal bidder would report channel 3 instead of channel 2. It sets a bid exactly equal to the threshold, where an inclusive compare would wrongly raise the request. It holds the acknowledge high while a different source takes the lead, and a design that reloads on level would overwrite the captured winner. It also checks the error-flag type change, the counter/timer against a break event, a disabled event and an empty transmit FIFO, and every vector mode. A long random phase then compares all outputs each cycle against a behavioural model.

// File: rtl/intbid_pkg.sv
package intbid_pkg;
  localparam int TYPE_W = 3;
  localparam logic [TYPE_W-1:0] TY_COS   = 3'b001;
  localparam logic [TYPE_W-1:0] TY_TX    = 3'b010;
  localparam logic [TYPE_W-1:0] TY_RX    = 3'b011;
  localparam logic [TYPE_W-1:0] TY_BRK   = 3'b100;
  localparam logic [TYPE_W-1:0] TY_CT    = 3'b101;
  localparam logic [TYPE_W-1:0] TY_RXERR = 3'b111;
endpackage

// File: rtl/intbid_chan.sv
module intbid_chan
  import intbid_pkg::*;
#(
  parameter int CNT_W = 3,
  localparam int BID_W = CNT_W + TYPE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic             rx_err,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic             brk,
  input  logic             cos,
  input  logic             en_rx,
  input  logic             en_tx,
  input  logic             en_brk,
  input  logic             en_cos,
  output logic [BID_W-1:0] bid_o,
  output logic             valid_o
);
  localparam int NSRC = 4;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [BID_W-1:0] cand_bid [NSRC];
  logic [NSRC-1:0]  cand_ok;

  always_comb begin
    cand_bid[0] = {rx_cnt, rx_err ? TY_RXERR : TY_RX};
    cand_ok[0]  = en_rx && (rx_cnt != '0);
    cand_bid[1] = {tx_cnt, TY_TX};
    cand_ok[1]  = en_tx && (tx_cnt != '0);
    cand_bid[2] = {CNT_MAX, TY_BRK};
    cand_ok[2]  = en_brk && brk;
    cand_bid[3] = {CNT_MAX, TY_COS};
    cand_ok[3]  = en_cos && cos;
  end

  always_comb begin
    bid_o   = '0;
    valid_o = 1'b0;
    for (int s = 0; s < NSRC; s++) begin
      if (cand_ok[s] && (!valid_o || cand_bid[s] > bid_o)) begin
        bid_o   = cand_bid[s];
        valid_o = 1'b1;
      end
    end
  end

  AST_CHAN_ENABLED: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ((en_rx && rx_cnt != '0) || (en_tx && tx_cnt != '0) ||
                 (en_brk && brk) || (en_cos && cos))); // R2

  AST_CHAN_IDLE_COUNT: assert property (@(posedge clk) disable iff (rst)
    (valid_o && bid_o[TYPE_W-1:0] == TY_TX) |-> (tx_cnt != '0)); // R1
endmodule

// File: rtl/intbid_pick.sv
module intbid_pick
  import intbid_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 3,
  localparam int BID_W = CNT_W + TYPE_W,
  localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BID_W-1:0] ch_bid [NCH],
  input  logic [NCH-1:0]   ch_valid,
  input  logic             ct_valid,
  input  logic [BID_W-1:0] thresh,
  output logic             win_valid,
  output logic [CHW-1:0]   win_chan,
  output logic [BID_W-1:0] win_bid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [BID_W-1:0] CT_BID  = {CNT_MAX, TY_CT};

  logic [BID_W-1:0] best_bid;
  logic [CHW-1:0]   best_ch;
  logic             best_ok;
  logic             ct_sel;

  always_comb begin
    best_bid = '0;
    best_ch  = '0;
    best_ok  = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (ch_valid[i] && (!best_ok || ch_bid[i] > best_bid)) begin
        best_bid = ch_bid[i];
        best_ch  = CHW'(i);
        best_ok  = 1'b1;
      end
    end
    ct_sel    = ct_valid && (!best_ok || CT_BID > best_bid);
    win_bid   = ct_sel ? CT_BID : best_bid;
    win_chan  = ct_sel ? '0 : best_ch;
    win_valid = (ct_sel || best_ok) && (win_bid > thresh);
  end

  AST_WIN_ABOVE_THR: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (win_bid > thresh)); // R3

  AST_CT_BEATS_ALL: assert property (@(posedge clk) disable iff (rst)
    (win_valid && win_bid[TYPE_W-1:0] == TY_CT) |-> (win_chan == '0)); // R5

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_WIN_IS_MAX: assert property (@(posedge clk) disable iff (rst)
      (win_valid && ch_valid[g]) |-> (ch_bid[g] <= win_bid)); // R4
    AST_TIE_LOW_CHAN: assert property (@(posedge clk) disable iff (rst)
      (win_valid && ch_valid[g] && ch_bid[g] == win_bid &&
       win_bid[TYPE_W-1:0] != TY_CT) |-> (win_chan <= CHW'(g))); // R4
  end
endmodule

// File: rtl/intbid_vec.sv
module intbid_vec
  import intbid_pkg::*;
#(
  parameter int CHW   = 2,
  parameter int CNT_W = 3,
  parameter int VEC_W = 8,
  localparam int CIR_W = CHW + TYPE_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CIR_W-1:0] cir,
  input  logic [VEC_W-1:0] base,
  input  logic [1:0]       vctl,
  output logic [VEC_W-1:0] vec_o
);
  localparam int TOP_LO = TYPE_W + CHW;

  logic [CHW-1:0]    chan;
  logic [TYPE_W-1:0] ityp;
  logic [VEC_W-1:0]  vec_d;

  assign chan = cir[CIR_W-1 -: CHW];
  assign ityp = cir[CNT_W +: TYPE_W];

  always_comb begin
    unique case (vctl)
      2'b00:   vec_d = base;
      2'b01:   vec_d = {base[VEC_W-1:CHW], chan};
      2'b10:   vec_d = {base[VEC_W-1:TYPE_W], ityp};
      default: vec_d = {base[VEC_W-1:TOP_LO], ityp, chan};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) vec_o <= '0;
    else     vec_o <= vec_d;
  end

  AST_VEC_TOP_BITS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (vec_o[VEC_W-1:TOP_LO] == $past(base[VEC_W-1:TOP_LO]))); // R10
endmodule

// File: rtl/intbid_arb.sv
module intbid_arb
  import intbid_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 3,
  parameter int VEC_W = 8,
  localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BID_W = CNT_W + TYPE_W,
  localparam int CIR_W = CHW + TYPE_W + CNT_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH*CNT_W-1:0] rx_fill_i,
  input  logic [NCH-1:0]       rx_err_i,
  input  logic [NCH*CNT_W-1:0] tx_free_i,
  input  logic [NCH-1:0]       brk_i,
  input  logic [NCH-1:0]       cos_i,
  input  logic                 ct_i,
  input  logic [NCH-1:0]       en_rx_i,
  input  logic [NCH-1:0]       en_tx_i,
  input  logic [NCH-1:0]       en_brk_i,
  input  logic [NCH-1:0]       en_cos_i,
  input  logic                 en_ct_i,
  input  logic [BID_W-1:0]     thresh_i,
  input  logic [VEC_W-1:0]     base_i,
  input  logic [1:0]           vctl_i,
  input  logic                 ack_i,
  input  logic                 upd_i,
  output logic                 irq_n_o,
  output logic [CIR_W-1:0]     cir_o,
  output logic [VEC_W-1:0]     vec_o
);
  logic [BID_W-1:0] ch_bid [NCH];
  logic [NCH-1:0]   ch_valid;
  logic             win_valid;
  logic [CHW-1:0]   win_chan;
  logic [BID_W-1:0] win_bid;
  logic             ack_q;
  logic             load;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    intbid_chan #(.CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .rx_cnt  (rx_fill_i[c*CNT_W +: CNT_W]),
      .rx_err  (rx_err_i[c]),
      .tx_cnt  (tx_free_i[c*CNT_W +: CNT_W]),
      .brk     (brk_i[c]),
      .cos     (cos_i[c]),
      .en_rx   (en_rx_i[c]),
      .en_tx   (en_tx_i[c]),
      .en_brk  (en_brk_i[c]),
      .en_cos  (en_cos_i[c]),
      .bid_o   (ch_bid[c]),
      .valid_o (ch_valid[c])
    );
  end

  intbid_pick #(.NCH(NCH), .CNT_W(CNT_W)) u_pick (
    .clk       (clk),
    .rst       (rst),
    .ch_bid    (ch_bid),
    .ch_valid  (ch_valid),
    .ct_valid  (en_ct_i && ct_i),
    .thresh    (thresh_i),
    .win_valid (win_valid),
    .win_chan  (win_chan),
    .win_bid   (win_bid)
  );

  assign load = (ack_i && !ack_q) || upd_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n_o <= 1'b1;
      cir_o   <= '0;
      ack_q   <= 1'b0;
    end else begin
      irq_n_o <= !win_valid;
      ack_q   <= ack_i;
      if (load) begin
        if (win_valid)
          cir_o <= {win_chan, win_bid[TYPE_W-1:0], win_bid[BID_W-1:TYPE_W]};
        else
          cir_o <= '0;
      end
    end
  end

  intbid_vec #(.CHW(CHW), .CNT_W(CNT_W), .VEC_W(VEC_W)) u_vec (
    .clk   (clk),
    .rst   (rst),
    .cir   (cir_o),
    .base  (base_i),
    .vctl  (vctl_i),
    .vec_o (vec_o)
  );

  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    !win_valid |=> irq_n_o); // R6
  AST_IRQ_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    win_valid |=> !irq_n_o); // R6
  AST_CIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ack_i && ack_q && !upd_i) |=> $stable(cir_o)); // R8
  AST_CIR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (upd_i && !win_valid) |=> (cir_o == '0)); // R7
  AST_CIR_ABOVE_THR: assert property (@(posedge clk) disable iff (rst)
    (upd_i && win_valid) |=> (cir_o != '0)); // R9
endmodule

// File: tb/intbid_arb_tb.sv
module intbid_arb_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] rx_fill_i = '0;
  logic [3:0]  rx_err_i = '0;
  logic [11:0] tx_free_i = '0;
  logic [3:0]  brk_i = '0, cos_i = '0;
  logic        ct_i = 1'b0;
  logic [3:0]  en_rx_i = '1, en_tx_i = '1, en_brk_i = '1, en_cos_i = '1;
  logic        en_ct_i = 1'b1;
  logic [5:0]  thresh_i = '0;
  logic [7:0]  base_i = 8'hA0;
  logic [1:0]  vctl_i = 2'b11;
  logic        ack_i = 1'b0, upd_i = 1'b0;
  logic        irq_n_o;
  logic [7:0]  cir_o, vec_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  intbid_arb u_dut (.*);

  // behavioural reference
  logic       m_irq_n;
  logic [7:0] m_cir, m_vec;
  logic       m_ack;

  function automatic logic [8:0] m_win();
    int best = -1;
    int bch = 0;
    int b;
    for (int c = 0; c < 4; c++) begin
      int rf = rx_fill_i[c*3 +: 3];
      int tf = tx_free_i[c*3 +: 3];
      int bids[4];
      bit oks[4];
      bids[0] = rf*8 + (rx_err_i[c] ? 7 : 3); oks[0] = en_rx_i[c] && rf != 0;
      bids[1] = tf*8 + 2;                     oks[1] = en_tx_i[c] && tf != 0;
      bids[2] = 60;                           oks[2] = en_brk_i[c] && brk_i[c];
      bids[3] = 57;                           oks[3] = en_cos_i[c] && cos_i[c];
      for (int s = 0; s < 4; s++)
        if (oks[s] && bids[s] > int'(thresh_i) && bids[s] > best) begin
          best = bids[s]; bch = c;
        end
    end
    if (en_ct_i && ct_i && 61 > int'(thresh_i) && 61 > best) begin
      best = 61; bch = 0;
    end
    if (best < 0) return 9'h0;
    b = best;
    return {1'b1, bch[1:0], b[2:0], b[5:3]};
  endfunction

  function automatic logic [7:0] m_vecf(logic [7:0] c);
    case (vctl_i)
      2'b00:   return base_i;
      2'b01:   return {base_i[7:2], c[7:6]};
      2'b10:   return {base_i[7:3], c[5:3]};
      default: return {base_i[7:5], c[5:3], c[7:6]};
    endcase
  endfunction

  always @(posedge clk) begin
    logic [8:0] w;
    w = m_win();
    if (rst) begin
      m_irq_n <= 1'b1; m_cir <= '0; m_vec <= '0; m_ack <= 1'b0;
    end else begin
      m_irq_n <= !w[8];
      m_ack   <= ack_i;
      if ((ack_i && !m_ack) || upd_i) m_cir <= w[8] ? w[7:0] : 8'h00;
      m_vec   <= m_vecf(m_cir);
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      chk("R6 irq_n", {7'b0, irq_n_o}, {7'b0, m_irq_n});
      chk("R7 cir", cir_o, m_cir);
      chk("R10 vec", vec_o, m_vec);
    end
  end

  task automatic clear_src();
    rx_fill_i = '0; rx_err_i = '0; tx_free_i = '0;
    brk_i = '0; cos_i = '0; ct_i = 1'b0;
    en_rx_i = '1; en_tx_i = '1; en_brk_i = '1; en_cos_i = '1; en_ct_i = 1'b1;
    thresh_i = '0;
  endtask

  task automatic pulse_upd();
    upd_i = 1'b1; @(negedge clk); upd_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 irq_n", {7'b0, irq_n_o}, 8'h01);
    chk("R11 cir", cir_o, 8'h00);
    chk("R11 vec", vec_o, 8'h00);
    rst = 1'b0;

    // R1: receive bid of channel 1, fill 3, captured on acknowledge rise
    rx_fill_i[3 +: 3] = 3'd3; ack_i = 1'b1;
    @(negedge clk);
    chk("R1 rx bid", cir_o, 8'h5B);
    chk("R6 irq low", {7'b0, irq_n_o}, 8'h00);
    ack_i = 1'b0;
    @(negedge clk);
    chk("R10 mode11", vec_o, 8'hAD);
    vctl_i = 2'b00; @(negedge clk); chk("R10 mode00", vec_o, 8'hA0);
    vctl_i = 2'b01; @(negedge clk); chk("R10 mode01", vec_o, 8'hA1);
    vctl_i = 2'b10; @(negedge clk); chk("R10 mode10", vec_o, 8'hA3);
    vctl_i = 2'b11;

    // R1: error flag switches the type code
    rx_err_i[1] = 1'b1; ack_i = 1'b1;
    @(negedge clk);
    chk("R1 rx err type", cir_o, 8'h7B);

    // R8: acknowledge held, new leader appears
    rx_fill_i = '0; rx_err_i = '0; tx_free_i[6 +: 3] = 3'd5;
    repeat (2) @(negedge clk);
    chk("R8 hold", cir_o, 8'h7B);
    ack_i = 1'b0;
    @(negedge clk);

    // R4 and R9: equal transmit bids on channels 2 and 3, update command
    tx_free_i[9 +: 3] = 3'd5;
    pulse_upd();
    chk("R4 tie low chan", cir_o, 8'h95);
    chk("R9 update load", cir_o, 8'h95);

    // R5: counter/timer beats break, loses to receive with error at fill 7
    clear_src(); brk_i[0] = 1'b1; ct_i = 1'b1;
    pulse_upd();
    chk("R5 ct wins", cir_o, 8'h2F);
    rx_fill_i[0 +: 3] = 3'd7; rx_err_i[0] = 1'b1;
    pulse_upd();
    chk("R5 ct loses", cir_o, 8'h3F);

    // R3: bid equal to threshold does not qualify
    clear_src(); rx_fill_i[3 +: 3] = 3'd3; thresh_i = 6'd27;
    repeat (2) @(negedge clk);
    chk("R3 equal blocked", {7'b0, irq_n_o}, 8'h01);
    thresh_i = 6'd26;
    @(negedge clk);
    chk("R3 above passes", {7'b0, irq_n_o}, 8'h00);

    // R2: disabled break source; R7: load with no winner gives zero
    clear_src(); brk_i[0] = 1'b1; en_brk_i[0] = 1'b0;
    pulse_upd();
    chk("R2 disabled", {7'b0, irq_n_o}, 8'h01);
    chk("R7 empty load", cir_o, 8'h00);

    // R1: empty transmit count does not bid
    clear_src(); tx_free_i = '0; en_tx_i = '1;
    @(negedge clk);
    chk("R1 tx zero", {7'b0, irq_n_o}, 8'h01);

    // random phase, compared every cycle by the model
    for (int n = 0; n < 2000; n++) begin
      rx_fill_i = 12'($urandom); tx_free_i = 12'($urandom);
      rx_err_i = 4'($urandom); brk_i = 4'($urandom & $urandom);
      cos_i = 4'($urandom & $urandom); ct_i = 1'($urandom);
      en_rx_i = 4'($urandom); en_tx_i = 4'($urandom);
      en_brk_i = 4'($urandom); en_cos_i = 4'($urandom);
      en_ct_i = 1'($urandom); thresh_i = 6'($urandom);
      base_i = 8'($urandom); vctl_i = 2'($urandom);
      ack_i = ($urandom % 3) == 0; upd_i = ($urandom % 5) == 0;
      @(negedge clk);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule